// File: doc/BRIEF.md
# Phased SPI Flash Transaction Engine

This block is an SPI master that runs one complete bus transaction per start pulse. The transaction walks through up to four phases in a fixed order: an opcode byte, an address of zero to four bytes, a run of idle (dummy) clock cycles, and a block of data bytes. Any phase whose length is zero is skipped. Software cannot drive chip select itself. The engine lowers the chosen select line when the transaction begins and raises it once the last bit has been clocked. A write part and a read part therefore have to be expressed inside one transaction.

Configuration arrives on plain input ports and is captured on the start pulse. The opcode and address always travel on one lane. The data phase may use one, two or four lanes; a build parameter can remove the four-lane mode. Transmit bytes come in through a valid/ready stream, and received bytes leave through another valid/ready stream. SCLK is stretched (held low) whenever either stream is not ready, so that no bit is dropped or repeated. The bus is SPI mode 0: SCLK idles low, data changes after a falling edge and is sampled on a rising edge, most significant bit first. One SCLK period lasts `CLK_DIV` system clocks, where `CLK_DIV` is even and at least 2.

Top module: `spi_phase_engine`

## Requirements
- R1: Within one transaction the bus carries the opcode byte first, then the address bytes, then the idle cycles, then the data bytes. Opcode and address go MSB first on `sd_o[0]` alone with `sd_oe` = 4'b0001, and each bit is stable at the rising SCLK edge.
- R2: A phase of length zero produces no SCLK cycles. Opcode length is 0 or 8 bits (`cfg_cmd_en`), address length is `cfg_addr_len` bytes, and data length is `cfg_data_len` bytes (16 bits, up to 65535). If all lengths are zero, the transaction has no SCLK cycles at all.
- R3: From the cycle after an accepted start until the end, exactly one `cs_n` bit is low, the one at index `cfg_sel`. All `cs_n` bits are high in reset, when idle, and at every rising SCLK edge outside the selected pattern (never).
- R4: A start is refused when `cfg_sel` is 5 to 7, when `cfg_addr_len` is above 4, or when the lane code is unsupported. A refused start gives a one-cycle `err` pulse in the next cycle, and `busy` and `cs_n` do not change.
- R5: Lane codes: 0 = one lane (out on `sd_o[0]`, in on `sd_i[1]`), 1 = two lanes (`[1:0]`, higher-order bit on lane 1), 2 = four lanes (`[3:0]`, higher-order bit on lane 3), 3 = invalid. Code 2 is also invalid when `QUAD_EN` is 0. Transmit data enables exactly the active lanes; receive data drives no lane.
- R6: The idle phase lasts `cfg_gap_len` SCLK cycles, and all output enables are off during it.
- R7: `busy` rises in the cycle after an accepted start. `cs_n` returns to all-high first. In the next cycle `busy` falls and `done` pulses for one cycle. A start that arrives while `busy` is high has no effect.
- R8: In a write, SCLK stays low while the engine needs a byte and `tx_valid` is low. Each byte is taken exactly once.
- R9: In a read, SCLK stays low before the last bit of a byte as long as the previous byte is still held (`rx_valid` high, `rx_ready` low). `rx_data` stays stable while it waits, and every byte arrives once, in order.
- R10: SCLK idles low. When no stream stalls, consecutive rising edges within the opcode and address phases are `CLK_DIV` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction with the present configuration |
| cfg_sel | input | SEL_W (3) | Index of the chip select to use |
| cfg_cmd_en | input | 1 | Send the opcode byte |
| cfg_cmd | input | 8 | Opcode byte |
| cfg_addr_len | input | 3 | Address length in bytes, 0 to 4 |
| cfg_addr | input | 32 | Address, right-aligned |
| cfg_gap_len | input | GAP_W (8) | Idle SCLK cycles |
| cfg_data_len | input | LEN_W (16) | Data bytes |
| cfg_read | input | 1 | 1 = data phase receives, 0 = transmits |
| cfg_lanes | input | 2 | Data lane code |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | One-cycle refused-start pulse |
| sclk | output | 1 | Serial clock |
| cs_n | output | NUM_CS (5) | Active-low chip selects |
| sd_o | output | 4 | Data lane outputs |
| sd_oe | output | 4 | Data lane output enables |
| sd_i | input | 4 | Data lane inputs |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte present |
| tx_ready | output | 1 | Transmit byte taken this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte present |
| rx_ready | input | 1 | Consumer takes the received byte |

## Verification
A bus model checks lane values and enables at every rising SCLK edge and counts the edges against the configured phase lengths. A design that skipped a phase wrongly, used the wrong lane order or enabled drivers in the idle phase would fail the stream or count checks. Both streams are stalled in the middle of a transfer. An engine that kept clocking would lose a received byte or clock stale transmit bits, and the edge count taken during the stall shows this. Refused selects, oversize addresses and bad lane codes are tried, along with a start pulse sent while busy, to catch a design that starts anyway or switches its chip select partway through. The busy/done timing around the release of chip select is checked cycle by cycle.

// File: rtl/spi_phase_pkg.sv
package spi_phase_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_LOW, ST_HIGH, ST_TAIL, ST_FIN
    } st_e;

    // Phase order is behaviour: the sequencer walks these upwards.
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_GAP  = 2'd2,
        PH_DATA = 2'd3
    } ph_e;
endpackage

// File: rtl/spi_next_phase.sv
module spi_next_phase
    import spi_phase_pkg::*;
(
    input  ph_e        cur,
    input  logic       from_start,
    input  logic [3:0] en,
    output logic       valid,
    output ph_e        nxt
);
    always_comb begin
        valid = 1'b0;
        nxt   = PH_CMD;
        for (int i = 3; i >= 0; i--) begin
            if (en[i] && (from_start || i > int'(cur))) begin
                valid = 1'b1;
                nxt   = ph_e'(2'(i));
            end
        end
    end
endmodule

// File: rtl/spi_lane_map.sv
module spi_lane_map #(
    parameter bit QUAD_EN = 1'b1
) (
    input  logic [1:0] lanes,
    input  logic [1:0] chk_lanes,
    input  logic [3:0] sh_top,
    input  logic [7:0] rxs,
    input  logic [3:0] sd_i,
    output logic [2:0] w,
    output logic [3:0] byte_cyc,
    output logic [3:0] data_o,
    output logic [3:0] data_oe,
    output logic [7:0] rxs_next,
    output logic       lanes_ok
);
    always_comb begin
        case (lanes)
            2'd1: begin
                w = 3'd2; byte_cyc = 4'd4;
                data_o = {2'b00, sh_top[3:2]}; data_oe = 4'b0011;
                rxs_next = {rxs[5:0], sd_i[1:0]};
            end
            2'd2: begin
                w = 3'd4; byte_cyc = 4'd2;
                data_o = sh_top; data_oe = 4'b1111;
                rxs_next = {rxs[3:0], sd_i};
            end
            default: begin
                w = 3'd1; byte_cyc = 4'd8;
                data_o = {3'b000, sh_top[3]}; data_oe = 4'b0001;
                rxs_next = {rxs[6:0], sd_i[1]};
            end
        endcase
    end

    generate
        if (QUAD_EN) begin : g_quad
            assign lanes_ok = (chk_lanes != 2'd3);
        end else begin : g_dual
            assign lanes_ok = (chk_lanes < 2'd2);
        end
    endgenerate
endmodule

// File: rtl/spi_phase_engine.sv
module spi_phase_engine
    import spi_phase_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int NUM_CS  = 5,
    parameter int SEL_W   = 3,
    parameter int LEN_W   = 16,
    parameter int GAP_W   = 8,
    parameter bit QUAD_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_cmd_en,
    input  logic [7:0]        cfg_cmd,
    input  logic [2:0]        cfg_addr_len,
    input  logic [31:0]       cfg_addr,
    input  logic [GAP_W-1:0]  cfg_gap_len,
    input  logic [LEN_W-1:0]  cfg_data_len,
    input  logic              cfg_read,
    input  logic [1:0]        cfg_lanes,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              sclk,
    output logic [NUM_CS-1:0] cs_n,
    output logic [3:0]        sd_o,
    output logic [3:0]        sd_oe,
    input  logic [3:0]        sd_i,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    input  logic              rx_ready
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CW    = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int CYC_W = (GAP_W > 6) ? GAP_W : 6;
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);

    typedef struct packed {
        st_e               st;
        ph_e               ph;
        logic [CW-1:0]     cnt;
        logic [CYC_W-1:0]  cyc;
        logic [LEN_W-1:0]  bytes;
        logic [31:0]       sh;
        logic [7:0]        rxs;
        logic              need_tx;
        logic              sclk;
        logic [NUM_CS-1:0] cs_n;
        logic              busy;
        logic              done;
        logic              err;
        logic [7:0]        rx_data;
        logic              rx_valid;
        logic [SEL_W-1:0]  sel;
        logic              cmd_en;
        logic [7:0]        cmd;
        logic [2:0]        alen;
        logic [31:0]       addr;
        logic [GAP_W-1:0]  gap;
        logic [LEN_W-1:0]  dlen;
        logic              rd;
        logic [1:0]        lanes;
    } regs_t;

    regs_t q, d;

    logic [NUM_CS-1:0] cs_dec;
    logic              np_valid, lanes_ok, cfg_bad, enter;
    ph_e               np;
    logic [2:0]        w, sh_amt;
    logic [3:0]        byte_cyc, data_o, data_oe;
    logic [7:0]        rxs_next;
    logic [5:0]        addr_pad;
    logic              rx_on, rx_last, rx_free, active;

    generate
        for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
            assign cs_dec[g] = (int'(cfg_sel) != g);
        end
    endgenerate

    spi_next_phase u_next (
        .cur        (q.ph),
        .from_start (q.st == ST_LOAD),
        .en         ({q.dlen != '0, q.gap != '0, q.alen != 3'd0, q.cmd_en}),
        .valid      (np_valid),
        .nxt        (np)
    );

    spi_lane_map #(.QUAD_EN(QUAD_EN)) u_lane (
        .lanes     (q.lanes),
        .chk_lanes (cfg_lanes),
        .sh_top    (q.sh[31:28]),
        .rxs       (q.rxs),
        .sd_i      (sd_i),
        .w         (w),
        .byte_cyc  (byte_cyc),
        .data_o    (data_o),
        .data_oe   (data_oe),
        .rxs_next  (rxs_next),
        .lanes_ok  (lanes_ok)
    );

    assign cfg_bad  = (int'(cfg_sel) >= NUM_CS) || (cfg_addr_len > 3'd4) || !lanes_ok;
    assign rx_on    = (q.ph == PH_DATA) && q.rd;
    assign rx_last  = rx_on && (q.cyc == CYC_W'(1));
    assign rx_free  = !q.rx_valid || rx_ready;
    assign sh_amt   = (q.ph == PH_DATA) ? w : 3'd1;
    assign addr_pad = {3'd4 - q.alen, 3'b000};
    assign active   = (q.st == ST_LOW) || (q.st == ST_HIGH);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.err   = 1'b0;
        enter   = 1'b0;
        if (q.rx_valid && rx_ready) d.rx_valid = 1'b0;
        case (q.st)
            ST_IDLE: if (start) begin
                if (cfg_bad) begin
                    d.err = 1'b1;
                end else begin
                    d.sel = cfg_sel;   d.cmd_en = cfg_cmd_en; d.cmd = cfg_cmd;
                    d.alen = cfg_addr_len; d.addr = cfg_addr; d.gap = cfg_gap_len;
                    d.dlen = cfg_data_len; d.rd = cfg_read; d.lanes = cfg_lanes;
                    d.cs_n = cs_dec;
                    d.busy = 1'b1;
                    d.st   = ST_LOAD;
                end
            end
            ST_LOAD: enter = 1'b1;
            ST_LOW: begin
                if (q.need_tx) begin
                    if (tx_valid) begin
                        d.sh      = {tx_data, 24'b0};
                        d.need_tx = 1'b0;
                        d.cnt     = '0;
                    end
                end else if (q.cnt == HALF_M1) begin
                    if (!(rx_last && !rx_free)) begin
                        d.sclk = 1'b1;
                        d.st   = ST_HIGH;
                        d.cnt  = '0;
                        if (rx_on) begin
                            d.rxs = rxs_next;
                            if (rx_last) begin
                                d.rx_data  = rxs_next;
                                d.rx_valid = 1'b1;
                            end
                        end
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_HIGH: begin
                if (q.cnt == HALF_M1) begin
                    d.sclk = 1'b0;
                    d.cnt  = '0;
                    d.cyc  = q.cyc - 1'b1;
                    if (q.cyc > CYC_W'(1)) begin
                        d.sh = q.sh << sh_amt;
                        d.st = ST_LOW;
                    end else if (q.ph == PH_DATA && q.bytes > LEN_W'(1)) begin
                        d.bytes   = q.bytes - 1'b1;
                        d.cyc     = CYC_W'(byte_cyc);
                        d.need_tx = !q.rd;
                        d.st      = ST_LOW;
                    end else begin
                        enter = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_TAIL: begin
                if (q.cnt == HALF_M1) begin
                    d.cs_n = '1;
                    d.cnt  = '0;
                    d.st   = ST_FIN;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_FIN: begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (enter) begin
            d.cnt = '0;
            if (np_valid) begin
                d.ph = np;
                d.st = ST_LOW;
                case (np)
                    PH_CMD:  begin d.sh = {q.cmd, 24'b0}; d.cyc = CYC_W'(8); end
                    PH_ADDR: begin d.sh = q.addr << addr_pad; d.cyc = CYC_W'({q.alen, 3'b000}); end
                    PH_GAP:  d.cyc = CYC_W'(q.gap);
                    default: begin
                        d.bytes   = q.dlen;
                        d.cyc     = CYC_W'(byte_cyc);
                        d.need_tx = !q.rd;
                        d.rxs     = 8'b0;
                    end
                endcase
            end else begin
                d.st = ST_TAIL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        sd_o  = 4'b0;
        sd_oe = 4'b0;
        if (active) begin
            if (q.ph == PH_CMD || q.ph == PH_ADDR) begin
                sd_o  = {3'b000, q.sh[31]};
                sd_oe = 4'b0001;
            end else if (q.ph == PH_DATA && !q.rd) begin
                sd_o  = data_o;
                sd_oe = data_oe;
            end
        end
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign err      = q.err;
    assign sclk     = q.sclk;
    assign cs_n     = q.cs_n;
    assign tx_ready = (q.st == ST_LOW) && q.need_tx;
    assign rx_data  = q.rx_data;
    assign rx_valid = q.rx_valid;

    a_r3_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~q.cs_n) <= 1);
    a_r7_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&q.cs_n) |=> (q.done && !q.busy));
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start) |=> $stable(q.sel));
    a_r10_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !q.sclk);
    a_r6_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (active && q.ph == PH_GAP) |-> (sd_oe == 4'b0));
    a_r8_take_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !q.sclk);
    a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rx_valid && !rx_ready) |=> (q.rx_valid && $stable(q.rx_data)));
    a_r4_refuse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> (!q.busy && &q.cs_n));
endmodule

// File: tb/spi_phase_engine_bench.sv
module spi_phase_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [2:0] cfg_sel = '0, cfg_addr_len = '0;
    logic cfg_cmd_en = 1'b0, cfg_read = 1'b0;
    logic [7:0] cfg_cmd = '0, cfg_gap_len = '0;
    logic [31:0] cfg_addr = '0;
    logic [15:0] cfg_data_len = '0;
    logic [1:0] cfg_lanes = '0;
    logic busy, done, err, sclk, tx_ready, rx_valid;
    logic [4:0] cs_n;
    logic [3:0] sd_o, sd_oe;
    logic [3:0] sd_i = '0;
    logic [7:0] tx_data = '0, rx_data;
    logic tx_valid = 1'b0, rx_ready = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_phase_engine u_spi_phase_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_sel(cfg_sel),
        .cfg_cmd_en(cfg_cmd_en), .cfg_cmd(cfg_cmd), .cfg_addr_len(cfg_addr_len),
        .cfg_addr(cfg_addr), .cfg_gap_len(cfg_gap_len), .cfg_data_len(cfg_data_len),
        .cfg_read(cfg_read), .cfg_lanes(cfg_lanes), .busy(busy), .done(done),
        .err(err), .sclk(sclk), .cs_n(cs_n), .sd_o(sd_o), .sd_oe(sd_oe),
        .sd_i(sd_i), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
    );

    int tests = 0, fails = 0;
    int kind [0:1023];
    int val  [0:1023];
    int rise_t [0:1023];
    int n_cyc = 0, cyc_i = 0, bad_bits = 0, bad_cs = 0, clk_n = 0, cur_w = 1;
    logic [4:0] exp_cs = '1;
    logic [7:0] tx_q [$];
    logic [7:0] exp_rx [$];
    bit tx_gate = 1'b1, tx_acc = 1'b0, sclk_prev = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) clk_n++;

    // bus model, transmit driver and receive scoreboard
    always @(negedge clk) begin
        int m;
        m = (1 << cur_w) - 1;
        if (sclk && !sclk_prev) begin
            if (cs_n != exp_cs) bad_cs++;
            if (cyc_i < n_cyc) begin
                rise_t[cyc_i] = clk_n;
                case (kind[cyc_i])
                    0: if (sd_oe != 4'b0001 || sd_o[0] != val[cyc_i][0]) bad_bits++;
                    2: if (int'(sd_oe) != m || (int'(sd_o) & m) != val[cyc_i]) bad_bits++;
                    default: if (sd_oe != 4'b0) bad_bits++;
                endcase
            end else begin
                bad_bits++;
            end
            cyc_i++;
        end
        sclk_prev = sclk;
        sd_i = 4'b0;
        if (cyc_i < n_cyc && kind[cyc_i] == 3) begin
            if (cur_w == 1) sd_i = {2'b00, val[cyc_i][0], 1'b0};
            else sd_i = 4'(val[cyc_i]);
        end
        if (tx_acc) void'(tx_q.pop_front());
        tx_valid = tx_gate && (tx_q.size() > 0);
        tx_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
        tx_acc   = tx_valid && tx_ready;
        if (rx_valid && rx_ready) begin
            if (exp_rx.size() == 0) check(1'b0, "R9 unexpected rx byte", int'(rx_data), 0);
            else check(rx_data == exp_rx.pop_front(), "R9 rx byte order", int'(rx_data), 0);
        end
    end

    task automatic plan(input bit ce, input logic [7:0] c, input int al, input logic [31:0] a,
                        input int gp, input int dl, input bit rd, input int ln, input int seed);
        int n, m;
        logic [7:0] b;
        n = 0;
        cur_w = 1 << ln;
        m = (1 << cur_w) - 1;
        if (ce) for (int i = 7; i >= 0; i--) begin kind[n] = 0; val[n] = int'(c[i]); n++; end
        for (int i = al*8-1; i >= 0; i--) begin kind[n] = 0; val[n] = int'(a[i]); n++; end
        for (int i = 0; i < gp; i++) begin kind[n] = 1; val[n] = 0; n++; end
        for (int i = 0; i < dl; i++) begin
            b = 8'(seed + i*59);
            if (rd) exp_rx.push_back(b); else tx_q.push_back(b);
            for (int k = 0; k < 8/cur_w; k++) begin
                kind[n] = rd ? 3 : 2;
                val[n]  = (int'(b) >> (8 - cur_w*(k+1))) & m;
                n++;
            end
        end
        n_cyc = n; cyc_i = 0; bad_bits = 0; bad_cs = 0;
        cfg_cmd_en = ce; cfg_cmd = c; cfg_addr_len = 3'(al); cfg_addr = a;
        cfg_gap_len = 8'(gp); cfg_data_len = 16'(dl); cfg_read = rd; cfg_lanes = 2'(ln);
    endtask

    task automatic launch(input int sel);
        exp_cs = ~(5'b1 << sel);
        cfg_sel = 3'(sel);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R7 busy after start", int'(busy), 1);
        check(cs_n == exp_cs, "R3 select after start", int'(cs_n), int'(exp_cs));
    endtask

    task automatic finish(input string tag);
        int g;
        g = 0;
        while (cs_n != 5'h1f && g < 20000) begin @(negedge clk); g++; end
        check(busy == 1'b1 && done == 1'b0, "R7 busy held at release", int'(busy), 1);
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R7 done pulse", int'(done), 1);
        check(cyc_i == n_cyc, {tag, " R2 SCLK count"}, cyc_i, n_cyc);
        check(bad_bits == 0, {tag, " R1 R5 R6 lane stream"}, bad_bits, 0);
        check(bad_cs == 0, {tag, " R3 select during edges"}, bad_cs, 0);
        check(exp_rx.size() == 0 && tx_q.size() == 0, {tag, " R8 R9 streams drained"},
              int'(exp_rx.size() + tx_q.size()), 0);
        @(negedge clk);
        check(done == 1'b0, "R7 done is one cycle", int'(done), 0);
    endtask

    task automatic refuse(input int sel, input int al, input int ln, input string req);
        cfg_sel = 3'(sel); cfg_addr_len = 3'(al); cfg_lanes = 2'(ln);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(err == 1'b1 && busy == 1'b0 && cs_n == 5'h1f, req, int'(err), 1);
        @(negedge clk);
        check(err == 1'b0 && busy == 1'b0 && sclk == 1'b0, {req, " single pulse"}, int'(err), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog all requirements", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 5'h1f && sclk == 1'b0 && busy == 1'b0 && sd_oe == 4'b0,
              "R3 R10 reset state", int'(cs_n), 'h1f);

        // R1 R6: full sequence, single lane write
        plan(1'b1, 8'hA5, 3, 32'h00C3_5A96, 4, 3, 1'b0, 0, 8'h11);
        launch(0); finish("R1 full write");

        // R10: opcode and address only, edge spacing
        plan(1'b1, 8'h3C, 2, 32'h0000_F00D, 0, 0, 1'b0, 0, 0);
        launch(4); finish("R10 cmd+addr");
        check(rise_t[n_cyc-1] - rise_t[0] == (n_cyc-1)*CLK_DIV, "R10 SCLK period",
              rise_t[n_cyc-1] - rise_t[0], (n_cyc-1)*CLK_DIV);

        // R2: data only read, then an empty transaction
        plan(1'b0, 8'h00, 0, 32'h0, 0, 2, 1'b1, 0, 8'h6E);
        launch(1); finish("R2 data only");
        plan(1'b0, 8'h00, 0, 32'h0, 0, 0, 1'b0, 0, 0);
        launch(2); finish("R2 empty");

        // R5 R7: dual read with a start poke while busy
        plan(1'b1, 8'hBB, 4, 32'h1234_5678, 8, 4, 1'b1, 1, 8'h2D);
        launch(3);
        repeat (20) @(negedge clk);
        cfg_sel = 3'd0; cfg_cmd = 8'h00; start = 1'b1;
        @(negedge clk); start = 1'b0;
        finish("R7 dual read, start ignored");

        // R5: quad write and quad read
        plan(1'b1, 8'h38, 3, 32'h00AB_CDEF, 0, 5, 1'b0, 2, 8'h80);
        launch(1); finish("R5 quad write");
        plan(1'b1, 8'hEB, 3, 32'h0001_0203, 6, 3, 1'b1, 2, 8'hC7);
        launch(2); finish("R5 quad read");

        // R8: transmit stall holds SCLK low
        tx_gate = 1'b0;
        plan(1'b1, 8'h02, 0, 32'h0, 0, 3, 1'b0, 0, 8'h47);
        launch(0);
        repeat (100) @(negedge clk);
        check(sclk == 1'b0 && cyc_i == 8, "R8 stalled at first data bit", cyc_i, 8);
        repeat (10) @(negedge clk);
        check(sclk == 1'b0 && cyc_i == 8, "R8 no edges while empty", cyc_i, 8);
        tx_gate = 1'b1;
        finish("R8 tx stall");

        // R9: receive stall before the last bit of the second byte
        rx_ready = 1'b0;
        plan(1'b0, 8'h00, 0, 32'h0, 0, 3, 1'b1, 0, 8'h9A);
        launch(4);
        repeat (150) @(negedge clk);
        check(sclk == 1'b0 && cyc_i == 15 && rx_valid == 1'b1, "R9 stalled before last bit",
              cyc_i, 15);
        check(rx_data == exp_rx[0], "R9 held byte stable", int'(rx_data), int'(exp_rx[0]));
        rx_ready = 1'b1;
        finish("R9 rx stall");

        // R4: refused starts
        refuse(5, 0, 0, "R4 select 5 refused");
        refuse(7, 0, 0, "R4 select 7 refused");
        refuse(0, 5, 0, "R4 address length 5 refused");
        refuse(0, 0, 3, "R4 R5 lane code 3 refused");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule